// File: doc/BRIEF.md
# Byte-Loaded Direct Digital Synthesizer Core

This core generates a sampled sine wave whose frequency is set by a 32-bit tuning word. A host writes that word, together with a phase/control byte, over an 8-bit bus, one byte per write strobe. The bytes collect in a staging register. A separate update strobe then copies the staged word into the operating register in a single cycle, so a frequency change never becomes visible partly written.

Each sample clock, the operating tuning word is added to a 32-bit phase accumulator. The top 10 bits of the accumulator, shifted by a phase offset taken from the control byte, address a 1024-entry sine table. The table is computed at elaboration time. At the nominal 125 MHz sample clock, the output frequency is tuning_word × 125 MHz / 2^32.

Top module: `dds_tuning_core`

## Requirements
- R1: While `rst_ni` is low, and after its release with no update strobe, `phase_o` and `sine_o` are 0 and stay 0. Reset clears the staging register, the operating register, the accumulator and the byte slot counter.
- R2: Each cycle with `wr_stb_i` high stores `data_i` in the staging slot chosen by the slot counter, and then advances the counter. Slot 0 holds the control byte. Slots 1 to 4 hold the tuning word, most significant byte first.
- R3: On every clock the accumulator adds the operating tuning word. With a tuning word of zero, the phase does not move.
- R4: `phase_o` equals accumulator bits [31:22] plus 32 × control bits [7:3], modulo 1024, with one register of latency. Control bits [2:0] have no effect.
- R5: The operating register changes only on an update strobe. Write strobes alone never change the output frequency or the phase offset.
- R6: An update strobe copies the staging register as it currently stands, even when fewer than five bytes have been written, and it clears the slot counter. The value of `data_i` during a lone update strobe is ignored.
- R7: When a write strobe and an update strobe fall in the same cycle, the byte is still stored in its slot. The transfer takes the staging contents from before that byte, and the slot counter becomes 0.
- R8: `sine_o` equals round(511 × sin(2π × `phase_o` / 1024)) as a signed 10-bit value, in the same cycle as `phase_o`.
- R9: After the fifth byte the slot counter wraps to 0, so a sixth byte overwrites the control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_stb_i | input | 1 | Byte write strobe, one byte per high cycle |
| upd_stb_i | input | 1 | Transfer staging register to operating register |
| data_i | input | 8 | Byte bus |
| phase_o | output | 10 | Table address of the current sample |
| sine_o | output | 10 | Signed sine sample |

## Verification
The write strobe and the update strobe can land in the same clock. In that cycle the core must store the new byte, transfer the older staged word, and clear the slot counter. The random stimulus raises both strobes together on purpose, and also issues updates after partial byte sequences. A reference model built from the requirements follows the staging register, the operating register and the accumulator. Every sample's phase and amplitude is compared with that model, so a wrong choice of which word gets transferred shows up as a phase-slope error.

// File: rtl/dds_pkg.sv
package dds_pkg;
  parameter int unsigned ACC_W  = 32;
  parameter int unsigned BYTE_W = 8;
  parameter int unsigned ADDR_W = 10;
  parameter int unsigned SAMP_W = 10;
  parameter int unsigned OFS_W  = 5;
  localparam int unsigned NUM_SLOTS = ACC_W / BYTE_W + 1;
  localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS);
  localparam int unsigned DEPTH     = 1 << ADDR_W;
  localparam real         PI_C      = 3.14159265358979;
endpackage

// File: rtl/dds_byte_loader.sv
module dds_byte_loader
  import dds_pkg::*;
#(
  parameter int unsigned AW = ACC_W,
  parameter int unsigned BW = BYTE_W,
  localparam int unsigned NS = AW / BW + 1,
  localparam int unsigned SW = $clog2(NS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          upd_i,
  input  logic [BW-1:0] data_i,
  output logic [AW-1:0] ftw_o,
  output logic [BW-1:0] ctrl_o
);
  logic [NS-1:0][BW-1:0] stage_q, op_q;
  logic [SW-1:0]         slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      op_q    <= '0;
      slot_q  <= '0;
    end else begin
      if (wr_i) stage_q[slot_q] <= data_i;
      if (upd_i) op_q <= stage_q;  // pre-write content on coincident strobes
      if (upd_i) slot_q <= '0;
      else if (wr_i) slot_q <= (slot_q == SW'(NS - 1)) ? '0 : slot_q + 1'b1;
    end
  end

  // slot 1 is the most significant tuning byte
  for (genvar j = 1; j < NS; j++) begin : g_ftw
    assign ftw_o[AW-1-BW*(j-1) -: BW] = op_q[j];
  end
  assign ctrl_o = op_q[0];

  assert_slot_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q < SW'(NS));
  assert_upd_clears_slot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> slot_q == '0);
  assert_op_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(op_q));
endmodule

// File: rtl/dds_phase_accum.sv
module dds_phase_accum
  import dds_pkg::*;
#(
  parameter int unsigned AW = ACC_W,
  parameter int unsigned PW = ADDR_W,
  parameter int unsigned OW = OFS_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ftw_i,
  input  logic [OW-1:0] ofs_i,
  output logic [PW-1:0] addr_o
);
  logic [AW-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_q + ftw_i;
  end

  assign addr_o = acc_q[AW-1 -: PW] + {ofs_i, {(PW-OW){1'b0}}};

  assert_zero_ftw_still_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ftw_i == '0 |=> $stable(acc_q));
endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom
  import dds_pkg::*;
#(
  parameter int unsigned PW = ADDR_W,
  parameter int unsigned DW = SAMP_W,
  localparam int unsigned N = 1 << PW,
  localparam real AMP = real'((1 << (DW - 1)) - 1)
) (
  input  logic        [PW-1:0] addr_i,
  output logic signed [DW-1:0] data_o
);
  logic signed [DW-1:0] rom [N];

  for (genvar i = 0; i < N; i++) begin : g_rom
    localparam real    ANG = 2.0 * PI_C * real'(i) / real'(N);
    localparam integer VAL = $rtoi($floor(AMP * $sin(ANG) + 0.5));
    assign rom[i] = DW'(VAL);
  end

  assign data_o = rom[addr_i];
endmodule

// File: rtl/dds_tuning_core.sv
module dds_tuning_core
  import dds_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_stb_i,
  input  logic                     upd_stb_i,
  input  logic [BYTE_W-1:0]        data_i,
  output logic [ADDR_W-1:0]        phase_o,
  output logic signed [SAMP_W-1:0] sine_o
);
  logic [ACC_W-1:0]         ftw;
  logic [BYTE_W-1:0]        ctrl;
  logic [ADDR_W-1:0]        addr;
  logic signed [SAMP_W-1:0] samp;

  dds_byte_loader #(.AW(ACC_W), .BW(BYTE_W)) i_loader (
    .clk_i, .rst_ni, .wr_i(wr_stb_i), .upd_i(upd_stb_i), .data_i,
    .ftw_o(ftw), .ctrl_o(ctrl)
  );

  // phase offset lives in the top bits of the control byte
  dds_phase_accum #(.AW(ACC_W), .PW(ADDR_W), .OW(OFS_W)) i_accum (
    .clk_i, .rst_ni, .ftw_i(ftw), .ofs_i(ctrl[BYTE_W-1 -: OFS_W]), .addr_o(addr)
  );

  dds_sine_rom #(.PW(ADDR_W), .DW(SAMP_W)) i_rom (.addr_i(addr), .data_o(samp));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o <= '0;
      sine_o  <= '0;
    end else begin
      phase_o <= addr;
      sine_o  <= samp;
    end
  end

  assert_zero_phase_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == '0 |-> sine_o == '0);
  assert_quarter_peak_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == ADDR_W'(DEPTH / 4) |-> sine_o == SAMP_W'((1 << (SAMP_W - 1)) - 1));
endmodule

// File: tb/test_dds_tuning_core.sv
module test_dds_tuning_core;
  logic clk = 0, rst_n = 0, wr = 0, upd = 0;
  logic [7:0] din = 0;
  logic [9:0] phase;
  logic signed [9:0] sine;
  int total = 0, bad = 0, cyc = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  dds_tuning_core i_dds_tuning_core (
    .clk_i(clk), .rst_ni(rst_n), .wr_stb_i(wr), .upd_stb_i(upd), .data_i(din),
    .phase_o(phase), .sine_o(sine)
  );

  // reference model built from the requirements
  logic [7:0]  m_stage [5];
  logic [7:0]  m_op [5];
  logic [2:0]  m_slot;
  logic [31:0] m_acc;
  logic [9:0]  m_phase;

  function automatic logic [31:0] op_word();
    return {m_op[1], m_op[2], m_op[3], m_op[4]};
  endfunction

  function automatic logic signed [9:0] sine_ref(input logic [9:0] p);
    real v = $floor(511.0 * $sin(2.0 * 3.14159265358979 * real'(p) / 1024.0) + 0.5);
    return 10'($rtoi(v));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 5; k++) begin m_stage[k] <= 0; m_op[k] <= 0; end
      m_slot <= 0; m_acc <= 0; m_phase <= 0;
    end else begin
      m_phase <= m_acc[31:22] + {m_op[0][7:3], 5'd0};
      m_acc <= m_acc + op_word();
      if (wr) m_stage[m_slot] <= din;
      if (upd) for (int k = 0; k < 5; k++) m_op[k] <= m_stage[k];
      if (upd) m_slot <= 0;
      else if (wr) m_slot <= (m_slot == 4) ? 3'd0 : m_slot + 3'd1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    check({tag, " phase"}, int'(phase), int'(m_phase));
    check("R8 sine", int'(sine), int'(sine_ref(phase)));
    if (cyc > 100000) begin
      bad++;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input logic w, input logic u, input logic [7:0] d);
    @(posedge clk); #1;
    wr = w; upd = u; din = d;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, $urandom());
  endtask

  task automatic load(input logic [7:0] c, input logic [31:0] f);
    step(1, 0, c);
    step(1, 0, f[31:24]);
    step(1, 0, f[23:16]);
    step(1, 0, f[15:8]);
    step(1, 0, f[7:0]);
    step(0, 1, $urandom());  // R6: bus value ignored
  endtask

  initial begin
    void'($urandom(42));
    #1;
    check("R1 reset phase", int'(phase), 0);
    check("R1 reset sine", int'(sine), 0);
    #20 rst_n = 1;
    tag = "R1"; idle(6);
    check("R1 idle phase", int'(phase), 0);
    check("R8 table peak", int'(sine_ref(10'd256)), 511);
    // R3: quarter-cycle step gives 0,256,512,768
    tag = "R3"; load(8'h00, 32'h4000_0000); idle(12);
    // R4: offset 1/32 cycle, low control bits ignored
    tag = "R4"; load(8'h0F, 32'h0100_0000); idle(10);
    // R5: writes without update keep frequency
    tag = "R5"; step(1, 0, 8'hFF); step(1, 0, 8'h12); idle(8);
    // R6: partial load then update
    tag = "R6"; step(0, 1, 8'hAA); step(1, 0, 8'h00); step(1, 0, 8'h08);
    step(0, 1, 8'h55); idle(8);
    // R7: coincident write and update
    tag = "R7"; step(1, 0, 8'h00); step(1, 1, 8'h20); idle(4);
    step(1, 0, 8'h00); step(0, 1, 0); idle(6);
    // R9: sixth byte lands in the control slot
    tag = "R9"; for (int k = 0; k < 6; k++) step(1, 0, 8'h48 + 8'(k));
    step(0, 1, 0); idle(8);
    // R2: random traffic
    tag = "R2";
    for (int it = 0; it < 300; it++) begin
      int nb = $urandom_range(0, 7);
      for (int k = 0; k < nb; k++) step(1, ($urandom_range(0, 9) == 0), $urandom());
      step($urandom_range(0, 1), 1, $urandom());
      idle($urandom_range(0, 5));
    end
    tag = "R1"; rst_n = 0; #1;
    check("R1 rerun reset", int'(phase), 0);
    #9 rst_n = 1; idle(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule